// File: doc/BRIEF.md
# Range-Matching Address Translation Buffer

This block translates virtual addresses to physical addresses. It uses a fully associative store of entries that software loads. Each entry covers an inclusive span of virtual addresses, from a first address to a last address, rather than one fixed-size page tag. A translated lookup compares the request against every entry in parallel. The lowest-numbered valid entry whose span contains the address supplies the physical page base and an attribute word. The block adds the low 12 address bits to that base to form the physical address. The one store serves instruction fetches and data accesses alike.

A lookup request carries the virtual address, the access kind and a mode bit. When the mode bit is low, translation is disabled: the address passes straight through and all three permissions are granted. When no entry matches a translated request, the block reports a miss code. The code tells an instruction-fetch miss apart from a data miss. On a hit, the block passes the matched entry's attributes to a separate protection checker. A single write port installs an entry or invalidates one, selected by index.

Top module: `tlbr_top`

## Requirements
- R1: After reset every entry is invalid, so a translated lookup at any address misses.
- R2: An entry matches only when it is valid and first <= address <= last, with both bounds inclusive. An entry whose first address is greater than its last address never matches.
- R3: When several valid entries match, the response reports the one with the lowest index in `rsp_idx`, together with that entry's base and attributes.
- R4: On a hit, `rsp_pa` equals the entry's physical base plus the low 12 bits of the virtual address, modulo 2^PA_W. In the same response, `rsp_excp` is 0, `rsp_perm` is 0 and `rsp_attr` is the entry's attribute word.
- R5: When `req_xlate` is 0, the response has `rsp_pa` equal to the virtual address (zero-extended or truncated to PA_W), `rsp_perm` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute), `rsp_hit` = 0, `rsp_excp` = 0, `rsp_idx` = 0 and `rsp_attr` = 0. The entries are not consulted.
- R6: On a translated miss, `rsp_excp` is 2'd1 when `req_kind` is 2'd0 (fetch). It is 2'd2 for any other kind (2'd1 load, 2'd2 store). `rsp_hit`, `rsp_pa`, `rsp_perm`, `rsp_idx` and `rsp_attr` are all 0.
- R7: The response to a request accepted on one clock edge appears after that edge, with `rsp_valid` high for exactly one cycle. In a cycle without a request, `rsp_valid` is low and the other response outputs hold their values.
- R8: A write with `wr_valid` = 1 installs or overwrites the entry at `wr_idx`. A write with `wr_valid` = 0 invalidates it, so addresses covered only by that entry then miss.
- R9: A lookup in the same cycle as a write to a matching entry sees the contents from before the write. The new contents take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Index of the entry to write |
| wr_valid | input | 1 | Valid bit to store (0 invalidates) |
| wr_va_first | input | VA_W | First virtual address covered, inclusive |
| wr_va_last | input | VA_W | Last virtual address covered, inclusive |
| wr_pa_base | input | PA_W | Physical page base |
| wr_attr | input | ATTR_W | Attribute word: trap, dirty, break flags, 4-bit size, 3-bit rights type, two 2-bit privilege levels, 16-bit access id |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_xlate | input | 1 | 1 translates, 0 passes the address through |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_pa | output | PA_W | Physical address |
| rsp_idx | output | IDX_W | Index of the matched entry |
| rsp_excp | output | 2 | 0 none, 1 instruction miss, 2 data miss |
| rsp_perm | output | 3 | Granted read/write/execute, set only in pass-through mode |
| rsp_attr | output | ATTR_W | Attributes of the matched entry, for the protection checker |

## Verification
The port signs of a wrong internal state are these. A corrupt or stuck valid bit, or an off-by-one bound compare, shows as a wrong hit or miss exactly at a span edge. A broken priority chain shows as the wrong `rsp_idx` inside an overlap. A bad offset path shows as a wrong `rsp_pa`. Each of these is visible in the response one cycle after the lookup that exposes it. The bench therefore sweeps every address of a small configuration against an arithmetic model, with spans chosen to put first and last addresses, overlaps, empty spans and single-address spans at the edges of the address space.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

    localparam int PAGE_BITS = 12;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_IMISS = 2'd1,
        EXC_DMISS = 2'd2
    } excp_e;

    typedef struct packed {
        logic        ref_trap;
        logic        dirty;
        logic        brk;
        logic [3:0]  pg_size;
        logic [2:0]  rights;
        logic [1:0]  priv_hi;
        logic [1:0]  priv_lo;
        logic [15:0] acc_id;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;

    function automatic excp_e miss_code(input logic [1:0] kind);
        return (kind == KIND_FETCH) ? EXC_IMISS : EXC_DMISS;
    endfunction

endpackage

// File: rtl/tlbr_store.sv
module tlbr_store import tlbr_pkg::*; #(
    parameter int N     = 256,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [VA_W-1:0]    wr_va_first,
    input  logic [VA_W-1:0]    wr_va_last,
    input  logic [PA_W-1:0]    wr_pa_base,
    input  attr_t              wr_attr,
    output logic               ent_valid [N],
    output logic [VA_W-1:0]    ent_first [N],
    output logic [VA_W-1:0]    ent_last  [N],
    output logic [PA_W-1:0]    ent_base  [N],
    output attr_t              ent_attr  [N]
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
            end else if (sel) begin
                ent_valid[g] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                ent_first[g] <= wr_va_first;
                ent_last[g]  <= wr_va_last;
                ent_base[g]  <= wr_pa_base;
                ent_attr[g]  <= wr_attr;
            end
        end
    end

endmodule

// File: rtl/tlbr_match.sv
module tlbr_match #(
    parameter int N     = 256,
    parameter int VA_W  = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic               ent_valid [N],
    input  logic [VA_W-1:0]    ent_first [N],
    input  logic [VA_W-1:0]    ent_last  [N],
    input  logic [VA_W-1:0]    addr,
    output logic               found,
    output logic [IDX_W-1:0]   match_idx
);

    logic [N-1:0] in_span;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign in_span[g] = ent_valid[g]
                         && (ent_first[g] <= addr)
                         && (addr <= ent_last[g]);
    end

    // Scan from the top down so that the lowest matching index is left last.
    always_comb begin
        found     = 1'b0;
        match_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (in_span[i]) begin
                found     = 1'b1;
                match_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlbr_top.sv
module tlbr_top import tlbr_pkg::*; #(
    parameter int N     = 256,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [VA_W-1:0]     wr_va_first,
    input  logic [VA_W-1:0]     wr_va_last,
    input  logic [PA_W-1:0]     wr_pa_base,
    input  logic [ATTR_W-1:0]   wr_attr,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_va,
    input  logic [1:0]          req_kind,
    input  logic                req_xlate,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [PA_W-1:0]     rsp_pa,
    output logic [IDX_W-1:0]    rsp_idx,
    output logic [1:0]          rsp_excp,
    output logic [2:0]          rsp_perm,
    output logic [ATTR_W-1:0]   rsp_attr
);

    logic             ent_valid [N];
    logic [VA_W-1:0]  ent_first [N];
    logic [VA_W-1:0]  ent_last  [N];
    logic [PA_W-1:0]  ent_base  [N];
    attr_t            ent_attr  [N];

    logic             found;
    logic [IDX_W-1:0] match_idx;

    tlbr_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_valid    (wr_valid),
        .wr_va_first (wr_va_first),
        .wr_va_last  (wr_va_last),
        .wr_pa_base  (wr_pa_base),
        .wr_attr     (attr_t'(wr_attr)),
        .ent_valid   (ent_valid),
        .ent_first   (ent_first),
        .ent_last    (ent_last),
        .ent_base    (ent_base),
        .ent_attr    (ent_attr)
    );

    tlbr_match #(.N(N), .VA_W(VA_W)) u_match (
        .ent_valid (ent_valid),
        .ent_first (ent_first),
        .ent_last  (ent_last),
        .addr      (req_va),
        .found     (found),
        .match_idx (match_idx)
    );

    typedef struct packed {
        logic             hit;
        logic [PA_W-1:0]  pa;
        logic [IDX_W-1:0] idx;
        excp_e            excp;
        logic [2:0]       perm;
        attr_t            attr;
    } rsp_t;

    rsp_t nxt, cur;

    always_comb begin
        nxt = '0;
        if (!req_xlate) begin
            nxt.pa   = PA_W'(req_va);
            nxt.perm = PERM_ALL;
        end else if (found) begin
            nxt.hit  = 1'b1;
            nxt.idx  = match_idx;
            nxt.pa   = ent_base[match_idx] + PA_W'(req_va[PAGE_BITS-1:0]);
            nxt.attr = ent_attr[match_idx];
        end else begin
            nxt.excp = miss_code(req_kind);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                cur <= nxt;
            end
        end
    end

    assign rsp_hit  = cur.hit;
    assign rsp_pa   = cur.pa;
    assign rsp_idx  = cur.idx;
    assign rsp_excp = cur.excp;
    assign rsp_perm = cur.perm;
    assign rsp_attr = cur.attr;

endmodule

// File: rtl/tlbr_checker.sv
module tlbr_checker import tlbr_pkg::*; #(
    parameter int N     = 256,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    localparam int IDX_W = $clog2(N)
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [VA_W-1:0]     req_va,
    input logic [1:0]          req_kind,
    input logic                req_xlate,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [PA_W-1:0]     rsp_pa,
    input logic [IDX_W-1:0]    rsp_idx,
    input logic [1:0]          rsp_excp,
    input logic [2:0]          rsp_perm,
    input logic [ATTR_W-1:0]   rsp_attr
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    assert_rsp_after_req_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                       && $stable(rsp_excp));

    assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_xlate |=> rsp_pa == PA_W'($past(req_va))
                                   && rsp_perm == PERM_ALL && !rsp_hit
                                   && rsp_excp == 2'd0);

    assert_fetch_miss_code_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_xlate && req_kind == KIND_FETCH
            |=> rsp_hit || rsp_excp == 2'd1);

    assert_data_miss_code_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_xlate && req_kind != KIND_FETCH
            |=> rsp_hit || rsp_excp == 2'd2);

    assert_miss_zeroed_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_excp != 2'd0
            |-> !rsp_hit && rsp_pa == '0 && rsp_idx == '0
                && rsp_perm == 3'b000 && rsp_attr == '0);

    assert_hit_clean_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_excp == 2'd0 && rsp_perm == 3'b000);

endmodule

bind tlbr_top tlbr_checker #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_kind  (req_kind),
    .req_xlate (req_xlate),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_idx   (rsp_idx),
    .rsp_excp  (rsp_excp),
    .rsp_perm  (rsp_perm),
    .rsp_attr  (rsp_attr)
);

// File: tb/sim_tlbr_top.sv
module sim_tlbr_top;

    localparam int N      = 8;
    localparam int VA_W   = 14;
    localparam int PA_W   = 16;
    localparam int IDX_W  = 3;
    localparam int ATTR_W = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic              wr_valid = 1'b0;
    logic [VA_W-1:0]   wr_va_first = '0;
    logic [VA_W-1:0]   wr_va_last = '0;
    logic [PA_W-1:0]   wr_pa_base = '0;
    logic [ATTR_W-1:0] wr_attr = '0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_va = '0;
    logic [1:0]        req_kind = '0;
    logic              req_xlate = 1'b0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [PA_W-1:0]   rsp_pa;
    logic [IDX_W-1:0]  rsp_idx;
    logic [1:0]        rsp_excp;
    logic [2:0]        rsp_perm;
    logic [ATTR_W-1:0] rsp_attr;

    tlbr_top #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u0 (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench-side model of what software has written.
    bit                m_valid [N];
    logic [VA_W-1:0]   m_first [N];
    logic [VA_W-1:0]   m_last  [N];
    logic [PA_W-1:0]   m_base  [N];
    logic [ATTR_W-1:0] m_attr  [N];

    logic              e_hit;
    logic [PA_W-1:0]   e_pa;
    logic [IDX_W-1:0]  e_idx;
    logic [1:0]        e_excp;
    logic [2:0]        e_perm;
    logic [ATTR_W-1:0] e_attr;

    function automatic logic [ATTR_W-1:0] attr_of(int i);
        return ATTR_W'(32'h0123_4567 * (i + 3) + i);
    endfunction

    task automatic predict(input logic [VA_W-1:0] va, input logic [1:0] kind,
                           input logic xl);
        e_hit = 0; e_pa = '0; e_idx = '0; e_excp = 2'd0; e_perm = 3'b000; e_attr = '0;
        if (!xl) begin
            e_pa = PA_W'(va);
            e_perm = 3'b111;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (!e_hit && m_valid[i] && m_first[i] <= va && va <= m_last[i]) begin
                    e_hit  = 1;
                    e_idx  = IDX_W'(i);
                    e_pa   = PA_W'((int'(m_base[i]) + int'(va % 4096)) % 65536);
                    e_attr = m_attr[i];
                end
            end
            if (!e_hit) e_excp = (kind == 2'd0) ? 2'd1 : 2'd2;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_pa !== e_pa
            || rsp_idx !== e_idx || rsp_excp !== e_excp || rsp_perm !== e_perm
            || rsp_attr !== e_attr) begin
            failures++;
            $display("FAIL %s va=%h: got v=%b hit=%b pa=%h idx=%0d ex=%0d perm=%b attr=%h exp hit=%b pa=%h idx=%0d ex=%0d perm=%b attr=%h",
                     tag, req_va, rsp_valid, rsp_hit, rsp_pa, rsp_idx, rsp_excp,
                     rsp_perm, rsp_attr, e_hit, e_pa, e_idx, e_excp, e_perm, e_attr);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] kind,
                          input logic xl, input string tag);
        @(negedge clk);
        req_valid = 1; req_va = va; req_kind = kind; req_xlate = xl;
        predict(va, kind, xl);
        @(negedge clk);
        req_valid = 0;
        check(tag);
    endtask

    task automatic put(input int i, input bit v, input logic [VA_W-1:0] f,
                       input logic [VA_W-1:0] l, input logic [PA_W-1:0] b);
        @(negedge clk);
        wr_en = 1; wr_idx = IDX_W'(i); wr_valid = v;
        wr_va_first = f; wr_va_last = l; wr_pa_base = b; wr_attr = attr_of(i);
        @(negedge clk);
        wr_en = 0;
        m_valid[i] = v; m_first[i] = f; m_last[i] = l; m_base[i] = b; m_attr[i] = attr_of(i);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: nothing hits after reset.
        for (int k = 0; k < 3; k++) begin
            lookup(14'h0000, 2'(k), 1'b1, "R1");
            lookup(14'h3FFF, 2'(k), 1'b1, "R1");
            lookup(14'h1234, 2'(k), 1'b1, "R1");
        end

        put(0, 1, 14'h0100, 14'h01FF, 16'h5000);
        put(1, 1, 14'h0180, 14'h0400, 16'hA000);
        put(2, 1, 14'h0800, 14'h0700, 16'h3000); // empty span
        put(3, 1, 14'h1000, 14'h1FFF, 16'h2000);
        put(5, 1, 14'h3FFF, 14'h3FFF, 16'hF000); // single address at the top
        put(6, 1, 14'h0000, 14'h0000, 16'h1000); // single address at zero
        put(7, 1, 14'h2000, 14'h2FFF, 16'h7000);
        put(7, 0, 14'h2000, 14'h2FFF, 16'h7000); // R8: invalidated at once

        // R2 R3 R4 R6: every address, the kind cycling with the address.
        for (int a = 0; a < (1 << VA_W); a++) begin
            lookup(VA_W'(a), 2'(a % 3), 1'b1, "R2 R3 R4 R6 sweep");
        end

        // Named span edges.
        lookup(14'h00FF, 2'd1, 1'b1, "R2 below first");
        lookup(14'h0100, 2'd1, 1'b1, "R2 first inclusive");
        lookup(14'h01FF, 2'd2, 1'b1, "R3 last of overlap");
        lookup(14'h0200, 2'd0, 1'b1, "R3 after lower entry");
        lookup(14'h0400, 2'd1, 1'b1, "R2 last inclusive");
        lookup(14'h0750, 2'd0, 1'b1, "R2 empty span");
        lookup(14'h3FFF, 2'd2, 1'b1, "R4 top address");
        lookup(14'h2800, 2'd0, 1'b1, "R6 fetch miss");
        lookup(14'h2800, 2'd2, 1'b1, "R6 store miss");

        // R5: pass-through mode, including addresses covered by entries.
        for (int a = 0; a < (1 << VA_W); a += 97) begin
            lookup(VA_W'(a), 2'(a % 3), 1'b0, "R5");
        end

        // R8: invalidating entry 0 exposes entry 1 in the overlap.
        put(0, 0, 14'h0100, 14'h01FF, 16'h5000);
        lookup(14'h0100, 2'd1, 1'b1, "R8 invalidated");
        lookup(14'h0180, 2'd1, 1'b1, "R8 overlap falls to next");
        put(3, 1, 14'h1000, 14'h10FF, 16'h9000);
        lookup(14'h1100, 2'd1, 1'b1, "R8 overwrite shrinks");
        lookup(14'h10FE, 2'd1, 1'b1, "R8 overwrite base");

        // R9: write and lookup in the same cycle see the old contents.
        @(negedge clk);
        wr_en = 1; wr_idx = 3'd4; wr_valid = 1;
        wr_va_first = 14'h3000; wr_va_last = 14'h30FF; wr_pa_base = 16'hC000;
        wr_attr = attr_of(4);
        req_valid = 1; req_va = 14'h3010; req_kind = 2'd1; req_xlate = 1;
        predict(14'h3010, 2'd1, 1'b1);
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        check("R9 old contents");
        m_valid[4] = 1; m_first[4] = 14'h3000; m_last[4] = 14'h30FF;
        m_base[4] = 16'hC000; m_attr[4] = attr_of(4);
        lookup(14'h3010, 2'd1, 1'b1, "R9 new contents");

        // R7: with no request the response strobe drops and outputs hold.
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_pa !== e_pa || rsp_hit !== e_hit
            || rsp_idx !== e_idx) begin
            failures++;
            $display("FAIL R7 idle: got v=%b pa=%h hit=%b exp v=0 pa=%h hit=%b",
                     rsp_valid, rsp_pa, rsp_hit, e_pa, e_hit);
        end

        // R1: reset clears the entries again.
        @(negedge clk); rst = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 strobe in reset: got %b exp 0", rsp_valid);
        end
        rst = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        lookup(14'h3010, 2'd0, 1'b1, "R1 after second reset");
        lookup(14'h3FFF, 2'd1, 1'b1, "R1 after second reset");

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion exp completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule